// File: doc/BRIEF.md
# PCI Host Bridge Register Block

This block is the CPU-facing register file of a PCI host controller. It sits on a 32-bit word bus. A 256-byte window at the bottom of its address space holds the bridge's own configuration header. Above that sit three control words:

- a configuration target address;
- a memory base, which keeps only a few bits;
- an I/O base, which keeps only a few bits.

Configuration cycles to downstream devices are indirect. Software first loads the target address. It then reads or writes a data port. The block turns each data-port access into one 32-bit request on a downstream config handshake and holds the CPU off until that request is acknowledged.

A second, independent path relocates a CPU-side I/O window into downstream I/O space. The window offset is passed through. The upper address bits come from the stored I/O base. All other request and response signals pass straight through.

CPU accesses use a one-cycle request pulse. A request is taken only while `cpu_busy` is low. Every accepted request ends with exactly one `cpu_rdy` pulse, which carries the read data and an error flag. Local registers answer in the cycle after acceptance. Data-port accesses answer in the cycle after the downstream acknowledge.

Top module: `pcihb_regs`

## Requirements
- R1: Offsets 0x000 to 0x0FC address the 64 header words (word n at offset 4n, byte lane 0 at the lowest address). Each word is fully writable and reads back what was last written.
- R2: After reset, header word 0x000 reads {device id, vendor id} = 0x0A011D5C with default parameters. Word 0x004 reads 0x02900080: the command half has the wait-cycle bit 7 set, and the status half has capability list bit 4, fast back-to-back bit 7 and medium select timing (bits 10:9 = 01). Every other header word reads 0.
- R3: Offset 0x1C0 is the configuration target address. All 32 bits are stored and read back unchanged. It resets to 0.
- R4: Offset 0x1C4 is the memory base. A write stores only the value ANDed with 0xFF000001; all other bits read 0. It resets to 0.
- R5: Offset 0x1C8 is the I/O base. A write stores only the value ANDed with 0xFFFC0001. It resets to 0.
- R6: A write to offset 0x220 raises `cfg_req` with `cfg_wr`=1, `cfg_addr` equal to the target address and `cfg_wdata` equal to the written word. It holds these until `cfg_ack`. `cpu_rdy` pulses in the cycle after the acknowledge.
- R7: A read of offset 0x220 raises `cfg_req` with `cfg_wr`=0 at the target address. The `cpu_rdy` pulse that follows the acknowledge returns the `cfg_rdata` sampled with it.
- R8: While a data-port access is outstanding, `cpu_busy` is 1 and any `cpu_req` is ignored: it produces no response and changes no register.
- R9: Reads of unmapped offsets return 0 with no error. Writes to them change nothing.
- R10: An access whose offset is not a multiple of 4, or whose byte enables are not 4'hF, gets `cpu_rdy` with `cpu_err`=1 and read data 0. It changes no state.
- R11: `io_out_addr` equals {I/O base bits 31:18, `io_in_off`[17:0]}. The request and write fields pass to the downstream side and the acknowledge and read data pass back, with no added cycle. A new I/O base takes effect in the cycle after its write.
- R12: After reset, `cpu_rdy`, `cpu_err`, `cpu_busy` and `cfg_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | One-cycle access request |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte offset in the register window |
| cpu_be | input | 4 | Byte enables, must be 4'hF |
| cpu_wdata | input | 32 | Write data |
| cpu_busy | output | 1 | Data-port access outstanding |
| cpu_rdy | output | 1 | Response pulse |
| cpu_err | output | 1 | Access rejected (valid with cpu_rdy) |
| cpu_rdata | output | 32 | Read data (valid with cpu_rdy) |
| cfg_req | output | 1 | Downstream config request, held until ack |
| cfg_wr | output | 1 | Config write when 1 |
| cfg_addr | output | 32 | Config target address |
| cfg_wdata | output | 32 | Config write data |
| cfg_ack | input | 1 | Config completion |
| cfg_rdata | input | 32 | Config read data, valid with ack |
| io_in_req | input | 1 | CPU-side I/O window request |
| io_in_wr | input | 1 | I/O write when 1 |
| io_in_off | input | IO_OFF_W | Offset inside the I/O window |
| io_in_wdata | input | 32 | I/O write data |
| io_in_ack | output | 1 | I/O completion to the CPU side |
| io_in_rdata | output | 32 | I/O read data to the CPU side |
| io_out_req | output | 1 | Downstream I/O request |
| io_out_wr | output | 1 | Downstream I/O write |
| io_out_addr | output | 32 | Relocated downstream I/O address |
| io_out_wdata | output | 32 | Downstream I/O write data |
| io_out_ack | input | 1 | Downstream I/O completion |
| io_out_rdata | input | 32 | Downstream I/O read data |

## Verification
Two functions can land on the same clock edge: a CPU write to the I/O base and a live I/O window transfer whose address depends on that base. The bench holds an I/O window request steady while it issues the base write. Before the accepting edge it checks that the relocated address still carries the old upper bits. After that edge it checks that the address carries the newly masked ones.

A second overlap is provoked by pulsing a CPU write to the target address while a data-port read is still waiting for its acknowledge. The access is judged ignored if three things hold: no extra response appears, the downstream request keeps the old address, and a later read-back returns the old value.

// File: rtl/pcihb_pkg.sv
package pcihb_pkg;
   localparam int unsigned OFS_CADDR  = 32'h1C0;
   localparam int unsigned OFS_MBASE  = 32'h1C4;
   localparam int unsigned OFS_IOBASE = 32'h1C8;
   localparam int unsigned OFS_CDATA  = 32'h220;
   localparam int unsigned WIN_BYTES  = 32'h224;

   localparam logic [31:0] MBASE_MASK = 32'hFF00_0001;

   // header reset halves
   localparam logic [15:0] CMD_RST  = 16'h0080; // wait-cycle control
   localparam logic [15:0] STAT_RST = 16'h0290; // caps list, fast b2b, medium select

   typedef enum logic [0:0] {ST_IDLE, ST_CFG} seq_e;

   function automatic logic [31:0] hdr_init(int idx, logic [15:0] vid, logic [15:0] did);
      case (idx)
         0:       return {did, vid};
         1:       return {STAT_RST, CMD_RST};
         default: return 32'h0;
      endcase
   endfunction
endpackage

// File: rtl/pcihb_mreg.sv
module pcihb_mreg #(
   parameter logic [31:0] MASK = 32'hFFFF_FFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [31:0] d,
   output logic [31:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 32'h0;
      else if (we) q <= d & MASK;
   end

   // R3 R4 R5: a write stores the masked value, otherwise the value holds
   p_mreg_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == ($past(d) & MASK)));
   p_mreg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/pcihb_hdr.sv
module pcihb_hdr
   import pcihb_pkg::*;
#(
   parameter int          WORDS = 64,
   parameter logic [15:0] VID   = 16'h1D5C,
   parameter logic [15:0] DID   = 16'h0A01
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(WORDS)-1:0] widx,
   input  logic [31:0]              wdata,
   input  logic [$clog2(WORDS)-1:0] ridx,
   output logic [31:0]              rdata
);
   localparam int IDX_W = $clog2(WORDS);

   generate
      if (WORDS < 2 || (1 << IDX_W) != WORDS) begin : g_bad_words
         $error("pcihb_hdr: WORDS must be a power of two of at least 2");
      end
   endgenerate

   logic [WORDS-1:0][31:0] mem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem[i] <= hdr_init(i, VID, DID);
      end else if (we) begin
         mem[widx] <= wdata;
      end
   end

   assign rdata = mem[ridx];

   // R10: without a write enable the header keeps every word
   p_hdr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(mem));
endmodule

// File: rtl/pcihb_regs.sv
module pcihb_regs
   import pcihb_pkg::*;
#(
   parameter int          ADDR_W    = 10,
   parameter int          HDR_WORDS = 64,
   parameter int          IO_OFF_W  = 18,
   parameter logic [15:0] VID       = 16'h1D5C,
   parameter logic [15:0] DID       = 16'h0A01
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_req,
   input  logic                cpu_wr,
   input  logic [ADDR_W-1:0]   cpu_addr,
   input  logic [3:0]          cpu_be,
   input  logic [31:0]         cpu_wdata,
   output logic                cpu_busy,
   output logic                cpu_rdy,
   output logic                cpu_err,
   output logic [31:0]         cpu_rdata,
   output logic                cfg_req,
   output logic                cfg_wr,
   output logic [31:0]         cfg_addr,
   output logic [31:0]         cfg_wdata,
   input  logic                cfg_ack,
   input  logic [31:0]         cfg_rdata,
   input  logic                io_in_req,
   input  logic                io_in_wr,
   input  logic [IO_OFF_W-1:0] io_in_off,
   input  logic [31:0]         io_in_wdata,
   output logic                io_in_ack,
   output logic [31:0]         io_in_rdata,
   output logic                io_out_req,
   output logic                io_out_wr,
   output logic [31:0]         io_out_addr,
   output logic [31:0]         io_out_wdata,
   input  logic                io_out_ack,
   input  logic [31:0]         io_out_rdata
);
   localparam int          HIDX_W    = $clog2(HDR_WORDS);
   localparam int unsigned HDR_BYTES = HDR_WORDS * 4;
   localparam logic [31:0] IOB_MASK  = (32'hFFFF_FFFF << IO_OFF_W) | 32'h1;

   generate
      if (ADDR_W < 10 || ADDR_W > 16) begin : g_bad_aw
         $error("pcihb_regs: ADDR_W must cover the 0x224-byte window");
      end
      if (HDR_BYTES > OFS_CADDR) begin : g_bad_hdr
         $error("pcihb_regs: header overlaps the control words");
      end
      if (IO_OFF_W < 2 || IO_OFF_W > 30) begin : g_bad_io
         $error("pcihb_regs: IO_OFF_W out of range");
      end
   endgenerate

   // ---------------- decode ----------------
   seq_e        st_q;
   logic [31:0] addr32;
   logic        take, misfit, is_hdr, hit_ca, hit_mb, hit_io, hit_cd;

   assign addr32 = 32'(cpu_addr);
   assign take   = cpu_req && (st_q == ST_IDLE);
   assign misfit = (cpu_addr[1:0] != 2'b00) || (cpu_be != 4'hF);
   assign is_hdr = addr32 < HDR_BYTES;
   assign hit_ca = addr32 == OFS_CADDR;
   assign hit_mb = addr32 == OFS_MBASE;
   assign hit_io = addr32 == OFS_IOBASE;
   assign hit_cd = addr32 == OFS_CDATA;

   logic wr_ok;
   assign wr_ok = take && cpu_wr && !misfit;

   // ---------------- storage ----------------
   logic [31:0] hdr_rd, ca_q, mb_q, iob_q;

   pcihb_hdr #(.WORDS(HDR_WORDS), .VID(VID), .DID(DID)) u_hdr (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_ok && is_hdr),
      .widx  (cpu_addr[HIDX_W+1:2]),
      .wdata (cpu_wdata),
      .ridx  (cpu_addr[HIDX_W+1:2]),
      .rdata (hdr_rd)
   );

   pcihb_mreg #(.MASK(32'hFFFF_FFFF)) u_caddr (
      .clk(clk), .rst_n(rst_n), .we(wr_ok && hit_ca), .d(cpu_wdata), .q(ca_q));
   pcihb_mreg #(.MASK(MBASE_MASK)) u_mbase (
      .clk(clk), .rst_n(rst_n), .we(wr_ok && hit_mb), .d(cpu_wdata), .q(mb_q));
   pcihb_mreg #(.MASK(IOB_MASK)) u_iobase (
      .clk(clk), .rst_n(rst_n), .we(wr_ok && hit_io), .d(cpu_wdata), .q(iob_q));

   logic [31:0] loc_rd;
   always_comb begin
      loc_rd = 32'h0;
      if (is_hdr)      loc_rd = hdr_rd;
      else if (hit_ca) loc_rd = ca_q;
      else if (hit_mb) loc_rd = mb_q;
      else if (hit_io) loc_rd = iob_q;
   end

   // ---------------- sequencer ----------------
   logic        dwr_q;
   logic [31:0] dwd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cpu_rdy   <= 1'b0;
         cpu_err   <= 1'b0;
         cpu_rdata <= 32'h0;
         dwr_q     <= 1'b0;
         dwd_q     <= 32'h0;
      end else begin
         cpu_rdy <= 1'b0;
         cpu_err <= 1'b0;
         case (st_q)
            ST_IDLE: if (take) begin
               if (misfit) begin
                  cpu_rdy   <= 1'b1;
                  cpu_err   <= 1'b1;
                  cpu_rdata <= 32'h0;
               end else if (hit_cd) begin
                  st_q  <= ST_CFG;
                  dwr_q <= cpu_wr;
                  dwd_q <= cpu_wdata;
               end else begin
                  cpu_rdy   <= 1'b1;
                  cpu_rdata <= cpu_wr ? 32'h0 : loc_rd;
               end
            end
            ST_CFG: if (cfg_ack) begin
               st_q      <= ST_IDLE;
               cpu_rdy   <= 1'b1;
               cpu_rdata <= dwr_q ? 32'h0 : cfg_rdata;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_busy  = (st_q == ST_CFG);
   assign cfg_req   = (st_q == ST_CFG);
   assign cfg_wr    = dwr_q;
   assign cfg_addr  = ca_q;
   assign cfg_wdata = dwd_q;

   // ---------------- I/O window relocation ----------------
   assign io_out_req   = io_in_req;
   assign io_out_wr    = io_in_wr;
   assign io_out_wdata = io_in_wdata;
   assign io_out_addr  = {iob_q[31:IO_OFF_W], io_in_off};
   assign io_in_ack    = io_out_ack;
   assign io_in_rdata  = io_out_rdata;

   // ---------------- assertions ----------------
   p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_addr) && $stable(cfg_wdata) && $stable(cfg_wr)));
   p_ack_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && cfg_ack) |=> (cpu_rdy && !cfg_req));
   p_wait_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && !cfg_ack) |=> !cpu_rdy);
   p_err_rdy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_err |-> (cpu_rdy && cpu_rdata == 32'h0));
   p_idle_rdy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_req && !cfg_req) |=> !cpu_rdy);
endmodule

// File: tb/pcihb_regs_bench.sv
module pcihb_regs_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CFG_LAT    = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 0, cpu_wr = 0;
   logic [9:0]  cpu_addr = '0;
   logic [3:0]  cpu_be = 4'hF;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_busy, cpu_rdy, cpu_err;
   logic [31:0] cpu_rdata;
   logic        cfg_req, cfg_wr;
   logic [31:0] cfg_addr, cfg_wdata;
   logic        cfg_ack = 0;
   logic [31:0] cfg_rdata = '0;
   logic        io_in_req = 0, io_in_wr = 0;
   logic [17:0] io_in_off = '0;
   logic [31:0] io_in_wdata = '0;
   logic        io_in_ack;
   logic [31:0] io_in_rdata;
   logic        io_out_req, io_out_wr;
   logic [31:0] io_out_addr, io_out_wdata;
   logic        io_out_ack = 0;
   logic [31:0] io_out_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcihb_regs u_pcihb_regs (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
      .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy), .cpu_rdy(cpu_rdy),
      .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
      .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
      .io_in_req(io_in_req), .io_in_wr(io_in_wr), .io_in_off(io_in_off),
      .io_in_wdata(io_in_wdata), .io_in_ack(io_in_ack), .io_in_rdata(io_in_rdata),
      .io_out_req(io_out_req), .io_out_wr(io_out_wr), .io_out_addr(io_out_addr),
      .io_out_wdata(io_out_wdata), .io_out_ack(io_out_ack), .io_out_rdata(io_out_rdata)
   );

   int total = 0;
   int bad   = 0;

   typedef struct {
      logic [31:0] d;
      logic        e;
      string       tag;
   } exp_t;
   exp_t sb[$];

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // downstream config space model
   logic [31:0] cmem [16];
   logic [31:0] seen_addr = '0, seen_wdata = '0;
   logic        seen_wr = 0;
   int          seen_n = 0;
   initial begin
      int cnt = 0;
      for (int i = 0; i < 16; i++) cmem[i] = 32'h1000_0000 + 32'(i);
      forever begin
         @(negedge clk);
         cfg_ack = 1'b0;
         if (cfg_req) begin
            cnt++;
            if (cnt == CFG_LAT) begin
               cnt        = 0;
               cfg_ack    = 1'b1;
               seen_addr  = cfg_addr;
               seen_wr    = cfg_wr;
               seen_wdata = cfg_wdata;
               seen_n++;
               if (cfg_wr) cmem[cfg_addr[5:2]] = cfg_wdata;
               cfg_rdata = cmem[cfg_addr[5:2]];
            end
         end
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && cpu_rdy) begin
         if (sb.size() == 0) begin
            total++; bad++;
            $display("FAIL R8 unexpected response act=%h exp=none", cpu_rdata);
         end else begin
            exp_t x;
            x = sb.pop_front();
            chk({x.tag, " data"}, cpu_rdata, x.d);
            chk({x.tag, " err"}, 32'(cpu_err), 32'(x.e));
         end
      end
   end

   task automatic start(logic wr, logic [9:0] a, logic [3:0] be, logic [31:0] wd,
                        logic [31:0] exp_d, logic exp_e, string tag);
      exp_t x;
      while (cpu_busy) @(negedge clk);
      x.d = exp_d; x.e = exp_e; x.tag = tag;
      sb.push_back(x);
      cpu_wr = wr; cpu_addr = a; cpu_be = be; cpu_wdata = wd; cpu_req = 1'b1;
   endtask

   task automatic finish();
      @(negedge clk);
      cpu_req = 1'b0;
      cpu_be  = 4'hF;
      while (sb.size() != 0) @(negedge clk);
   endtask

   task automatic acc(logic wr, logic [9:0] a, logic [31:0] wd, logic [31:0] exp_d, string tag);
      start(wr, a, 4'hF, wd, exp_d, 1'b0, tag);
      finish();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 rdy", 32'(cpu_rdy), 0);
      chk("R12 err", 32'(cpu_err), 0);
      chk("R12 busy", 32'(cpu_busy), 0);
      chk("R12 cfg_req", 32'(cfg_req), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 header reset values
      acc(0, 10'h000, 0, 32'h0A01_1D5C, "R2 id word");
      acc(0, 10'h004, 0, 32'h0290_0080, "R2 cmd/status");
      acc(0, 10'h008, 0, 32'h0, "R2 other word");
      acc(0, 10'h1C0, 0, 32'h0, "R3 reset");
      acc(0, 10'h1C4, 0, 32'h0, "R4 reset");
      acc(0, 10'h1C8, 0, 32'h0, "R5 reset");

      // R1 header read/write
      acc(1, 10'h0FC, 32'hCAFE_F00D, 32'h0, "R1 write");
      acc(0, 10'h0FC, 0, 32'hCAFE_F00D, "R1 last word");
      acc(1, 10'h004, 32'h1234_5678, 32'h0, "R1 write");
      acc(0, 10'h004, 0, 32'h1234_5678, "R1 word1");
      acc(0, 10'h0F8, 0, 32'h0, "R1 neighbour");

      // R3/R4/R5 masks
      acc(1, 10'h1C0, 32'h8000_0010, 32'h0, "R3 write");
      acc(0, 10'h1C0, 0, 32'h8000_0010, "R3 readback");
      acc(1, 10'h1C4, 32'hFFFF_FFFF, 32'h0, "R4 write");
      acc(0, 10'h1C4, 0, 32'hFF00_0001, "R4 mask ones");
      acc(1, 10'h1C4, 32'h1234_5678, 32'h0, "R4 write");
      acc(0, 10'h1C4, 0, 32'h1200_0000, "R4 mask pattern");
      acc(1, 10'h1C8, 32'hFFFF_FFFF, 32'h0, "R5 write");
      acc(0, 10'h1C8, 0, 32'hFFFC_0001, "R5 mask ones");
      acc(1, 10'h1C8, 32'h1234_5679, 32'h0, "R5 write");
      acc(0, 10'h1C8, 0, 32'h1234_0001, "R5 mask pattern");

      // R9 unmapped
      acc(0, 10'h100, 0, 32'h0, "R9 gap read");
      acc(1, 10'h1CC, 32'hFFFF_FFFF, 32'h0, "R9 gap write");
      acc(0, 10'h1CC, 0, 32'h0, "R9 gap readback");
      acc(0, 10'h3FC, 0, 32'h0, "R9 beyond window");
      acc(0, 10'h1C0, 0, 32'h8000_0010, "R9 caddr untouched");
      acc(0, 10'h1C4, 0, 32'h1200_0000, "R9 mbase untouched");

      // R10 rejected accesses
      start(1, 10'h1C0, 4'h3, 32'hDEAD_BEEF, 32'h0, 1'b1, "R10 partial be");
      finish();
      start(1, 10'h1C2, 4'hF, 32'hDEAD_BEEF, 32'h0, 1'b1, "R10 unaligned");
      finish();
      start(0, 10'h1C0, 4'h1, 0, 32'h0, 1'b1, "R10 read partial be");
      finish();
      start(1, 10'h0FE, 4'hF, 32'hDEAD_BEEF, 32'h0, 1'b1, "R10 hdr unaligned");
      finish();
      acc(0, 10'h1C0, 0, 32'h8000_0010, "R10 caddr kept");
      acc(0, 10'h0FC, 0, 32'hCAFE_F00D, "R10 header kept");

      // R6 data port write
      acc(1, 10'h1C0, 32'h0000_0008, 32'h0, "R6 set addr");
      acc(1, 10'h220, 32'hA5A5_0001, 32'h0, "R6 data write");
      chk("R6 cfg count", 32'(seen_n), 1);
      chk("R6 cfg addr", seen_addr, 32'h0000_0008);
      chk("R6 cfg wr", 32'(seen_wr), 1);
      chk("R6 cfg wdata", seen_wdata, 32'hA5A5_0001);

      // R7 data port read
      acc(0, 10'h220, 0, 32'hA5A5_0001, "R7 read back written");
      chk("R7 cfg wr", 32'(seen_wr), 0);
      cmem[5] = 32'h5555_AAAA;
      acc(1, 10'h1C0, 32'h0000_0014, 32'h0, "R7 set addr");
      acc(0, 10'h220, 0, 32'h5555_AAAA, "R7 read preset");
      chk("R7 cfg addr", seen_addr, 32'h0000_0014);

      // R8 request during outstanding config cycle is ignored
      start(0, 10'h220, 4'hF, 0, 32'h5555_AAAA, 1'b0, "R8 data read");
      @(negedge clk);
      cpu_req = 1'b0;
      chk("R8 busy", 32'(cpu_busy), 1);
      chk("R8 cfg_req", 32'(cfg_req), 1);
      cpu_wr = 1'b1; cpu_addr = 10'h1C0; cpu_wdata = 32'hDEAD_BEEF; cpu_req = 1'b1;
      @(negedge clk);
      cpu_req = 1'b0;
      while (sb.size() != 0) @(negedge clk);
      chk("R8 cfg addr old", seen_addr, 32'h0000_0014);
      repeat (2) @(negedge clk);
      acc(0, 10'h1C0, 0, 32'h0000_0014, "R8 caddr kept");

      // R11 I/O window relocation and passthrough
      acc(1, 10'h1C8, 32'h0004_0000, 32'h0, "R11 base A");
      io_in_req = 1'b1; io_in_wr = 1'b1; io_in_off = 18'h2_3456; io_in_wdata = 32'h7777_0001;
      io_out_ack = 1'b1; io_out_rdata = 32'h0BAD_CAFE;
      #1;
      chk("R11 addr A", io_out_addr, 32'h0006_3456);
      chk("R11 req pass", 32'(io_out_req), 1);
      chk("R11 wr pass", 32'(io_out_wr), 1);
      chk("R11 wdata pass", io_out_wdata, 32'h7777_0001);
      chk("R11 ack pass", 32'(io_in_ack), 1);
      chk("R11 rdata pass", io_in_rdata, 32'h0BAD_CAFE);
      // base write in the same cycle as a live window access
      start(1, 10'h1C8, 4'hF, 32'hABCF_FFFF, 32'h0, 1'b0, "R11 base B");
      #1;
      chk("R11 old base before edge", io_out_addr, 32'h0006_3456);
      finish();
      chk("R11 new base after edge", io_out_addr, 32'hABCE_3456);
      io_in_off = 18'h0_0000;
      #1;
      chk("R11 zero offset", io_out_addr, 32'hABCC_0000);
      io_in_req = 1'b0; io_out_ack = 1'b0;
      #1;
      chk("R11 req drop", 32'(io_out_req), 0);

      repeat (3) @(negedge clk);
      chk("R12 idle rdy", 32'(cpu_rdy), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule